// File: doc/BRIEF.md
# Quasi-Bidirectional Port Pin Bank

This block is an 8-bit general-purpose I/O port for a small microcontroller core. Every bit owns an output latch that the CPU loads with a single write strobe. The latch controls the pad directly. A 0 in the latch turns the bit's pull-down on, so the pin is driven low. A 1 in the latch turns the pull-down off. The pin then rests high through a weak pull-up, and an outside device can still pull it low. A build parameter removes the internal pull-up so the stage becomes open-drain. With that option a latch value of 1 leaves the pin floating unless a resistor on the board pulls it up.

The CPU has two separate read operations. A latch read returns what software last wrote. A pin read returns the level actually present on the pad. Pad samples pass through a two-flop synchronizer before they reach the read path. A bit therefore serves as an input only after a 1 has been written to its latch, and a pin read then returns the outside level. When no read strobe is active the read bus is all zeros, so several ports can be ORed onto one shared CPU bus. The asynchronous active-low reset is released synchronously inside the block, and it sets every latch bit to 1.

Top module: `qbd_port_bank`

## Requirements
- R1: Two clock edges after reset is released, the block is in this state: every latch bit is 1, `pad_pd_en` is 0x00, `pad_pu_en` is 0xFF (pull-up build) and `rd_data` is 0x00 with no strobe active.
- R2: A rising clock edge with `wr_en` high loads `wr_data` into the latches. Bit i of `wr_data` goes to bit i, where bit 0 is the LSB. When `wr_en` is low, the latches keep their value.
- R3: `pad_pd_en[i]` is the inverse of latch bit i, so a latch 0 drives the pin low.
- R4: With `OPEN_DRAIN=0`, `pad_pu_en[i]` equals latch bit i. With `OPEN_DRAIN=1`, `pad_pu_en` is always 0x00.
- R5: While `rd_latch_en` is high and `rd_pin_en` is low, `rd_data` shows the latch contents.
- R6: While `rd_pin_en` is high, `rd_data[i]` shows `pad_level_in[i]` as sampled two rising edges earlier.
- R7: When both strobes are high, the pin read wins.
- R8: When neither strobe is high, `rd_data` is 0x00.
- R9: After a 1 is written to a bit's latch, a pin read of that bit follows the outside level, both high and low. A bit with latch 0 reads back 0 on a pin read, because its own pull-down holds the pad low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Latch write strobe |
| wr_data | input | 8 | Byte to load into the latches |
| rd_pin_en | input | 1 | Pin read strobe |
| rd_latch_en | input | 1 | Latch read strobe |
| rd_data | output | 8 | Read data; zero when no strobe is active |
| pad_pd_en | output | 8 | Pull-down enable per bit |
| pad_pu_en | output | 8 | Weak pull-up enable per bit |
| pad_level_in | input | 8 | Level sampled at each pad |

## Verification
The assertions assume that the strobes and the write data are stable around each rising edge. They also assume that `pad_level_in` may change at any cycle, and for that reason no property compares the pin read path with the raw pad. The bench changes every input only at the falling clock edge. It models the pad as the outside level ANDed with the inverse of the pull-down, the way a real wired node behaves. It waits the two synchronizer edges before it predicts a pin read, except where it checks on purpose that the old value is still shown one edge after a change.

// File: rtl/port_pkg.sv
package port_pkg;
  typedef enum logic [1:0] {
    RSEL_NONE  = 2'd0,
    RSEL_LATCH = 2'd1,
    RSEL_PIN   = 2'd2
  } rsel_e;

  // pin read has priority over latch read
  function automatic rsel_e pick_src(input logic pin_rd, input logic latch_rd);
    if (pin_rd)        return RSEL_PIN;
    else if (latch_rd) return RSEL_LATCH;
    else               return RSEL_NONE;
  endfunction
endpackage

// File: rtl/port_rst_sync.sv
module port_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/port_latch.sv
module port_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         srst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] latch_q
);
  logic [W-1:0] latch_d;

  always_comb begin
    latch_d = latch_q;
    if (wr_en) latch_d = wr_data;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) latch_q <= '1;
    else         latch_q <= latch_d;
  end
endmodule

// File: rtl/port_pin_sync.sv
module port_pin_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         srst_n,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pin_q
);
  logic [STAGES-1:0][W-1:0] stage_q;
  logic [STAGES-1:0][W-1:0] stage_d;

  always_comb begin
    stage_d[0] = pad_in;
    for (int s = 1; s < STAGES; s++) stage_d[s] = stage_q[s-1];
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) stage_q <= '1;
    else         stage_q <= stage_d;
  end

  assign pin_q = stage_q[STAGES-1];
endmodule

// File: rtl/port_rdmux.sv
module port_rdmux
  import port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         rd_pin_en,
  input  logic         rd_latch_en,
  input  logic [W-1:0] pin_val,
  input  logic [W-1:0] latch_val,
  output logic [W-1:0] rd_data
);
  rsel_e sel;

  always_comb begin
    sel = pick_src(rd_pin_en, rd_latch_en);
    unique case (sel)
      RSEL_PIN:   rd_data = pin_val;
      RSEL_LATCH: rd_data = latch_val;
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/qbd_port_bank.sv
module qbd_port_bank #(
  parameter int WIDTH      = 8,
  parameter int SYNC_DEPTH = 2,
  parameter bit OPEN_DRAIN = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_pin_en,
  input  logic             rd_latch_en,
  output logic [WIDTH-1:0] rd_data,
  output logic [WIDTH-1:0] pad_pd_en,
  output logic [WIDTH-1:0] pad_pu_en,
  input  logic [WIDTH-1:0] pad_level_in
);
  localparam int RST_STAGES = 2;

  logic             srst_n;
  logic [WIDTH-1:0] latch_q;
  logic [WIDTH-1:0] pin_q;

  port_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  port_latch #(.W(WIDTH)) u_latch (
    .clk     (clk),
    .srst_n  (srst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .latch_q (latch_q)
  );

  port_pin_sync #(.W(WIDTH), .STAGES(SYNC_DEPTH)) u_sync (
    .clk    (clk),
    .srst_n (srst_n),
    .pad_in (pad_level_in),
    .pin_q  (pin_q)
  );

  port_rdmux #(.W(WIDTH)) u_rdmux (
    .rd_pin_en   (rd_pin_en),
    .rd_latch_en (rd_latch_en),
    .pin_val     (pin_q),
    .latch_val   (latch_q),
    .rd_data     (rd_data)
  );

  assign pad_pd_en = ~latch_q;

  generate
    if (OPEN_DRAIN) begin : g_od
      assign pad_pu_en = '0;
    end else begin : g_pu
      assign pad_pu_en = latch_q;
    end
  endgenerate
endmodule

// File: rtl/qbd_port_bank_chk.sv
module qbd_port_bank_chk #(
  parameter int WIDTH      = 8,
  parameter bit OPEN_DRAIN = 1'b0
) (
  input logic             clk,
  input logic             srst_n,
  input logic             wr_en,
  input logic [WIDTH-1:0] wr_data,
  input logic             rd_pin_en,
  input logic             rd_latch_en,
  input logic [WIDTH-1:0] rd_data,
  input logic [WIDTH-1:0] pad_pd_en,
  input logic [WIDTH-1:0] pad_pu_en
);
  // R2
  wr_load_chk: assert property (@(posedge clk) disable iff (!srst_n)
    wr_en |=> (pad_pd_en == ~$past(wr_data)));

  // R2
  wr_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !wr_en |=> $stable(pad_pd_en));

  // R4
  pullup_chk: assert property (@(posedge clk) disable iff (!srst_n)
    OPEN_DRAIN ? (pad_pu_en == '0) : (pad_pu_en == ~pad_pd_en));

  // R5
  latch_rd_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_latch_en && !rd_pin_en) |-> (rd_data == ~pad_pd_en));

  // R8
  idle_bus_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!rd_latch_en && !rd_pin_en) |-> (rd_data == '0));
endmodule

bind qbd_port_bank qbd_port_bank_chk #(.WIDTH(WIDTH), .OPEN_DRAIN(OPEN_DRAIN)) u_chk (
  .clk         (clk),
  .srst_n      (srst_n),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .rd_pin_en   (rd_pin_en),
  .rd_latch_en (rd_latch_en),
  .rd_data     (rd_data),
  .pad_pd_en   (pad_pd_en),
  .pad_pu_en   (pad_pu_en)
);

// File: tb/tb_qbd_port_bank.sv
`timescale 1ns/1ps
module tb_qbd_port_bank;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, rd_pin_en, rd_latch_en;
  logic [7:0] wr_data, ext_lvl, pad_lvl, pad_lvl_od;
  logic [7:0] rd_data, pd_en, pu_en;
  logic [7:0] rd_data_od, pd_en_od, pu_en_od;
  logic [7:0] latch_m;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  // pad node: low when own pull-down is on, otherwise the outside level
  assign pad_lvl    = ext_lvl & ~pd_en;
  assign pad_lvl_od = ext_lvl & ~pd_en_od;

  qbd_port_bank dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_pin_en(rd_pin_en), .rd_latch_en(rd_latch_en), .rd_data(rd_data),
    .pad_pd_en(pd_en), .pad_pu_en(pu_en), .pad_level_in(pad_lvl));

  qbd_port_bank #(.OPEN_DRAIN(1'b1)) dut_od (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_pin_en(rd_pin_en), .rd_latch_en(rd_latch_en), .rd_data(rd_data_od),
    .pad_pd_en(pd_en_od), .pad_pu_en(pu_en_od), .pad_level_in(pad_lvl_od));

  function automatic logic [7:0] exp_pin(input logic [7:0] lat, input logic [7:0] ext);
    return lat & ext;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0; wr_data = $urandom();
    latch_m = v;
  endtask

  task automatic set_ext_settle(input logic [7:0] e);
    @(negedge clk); ext_lvl = e;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic read_both_paths(input string tag);
    rd_latch_en = 1'b1; #1;
    chk({tag, " R5 latch read"}, rd_data, latch_m);
    rd_latch_en = 1'b0; rd_pin_en = 1'b1; #1;
    chk({tag, " R6 pin read"}, rd_data, exp_pin(latch_m, ext_lvl));
    rd_latch_en = 1'b1; #1;
    chk({tag, " R7 both strobes"}, rd_data, exp_pin(latch_m, ext_lvl));
    rd_latch_en = 1'b0; rd_pin_en = 1'b0; #1;
    chk({tag, " R8 idle bus"}, rd_data, 8'h00);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
    rd_pin_en = 1'b0; rd_latch_en = 1'b0; ext_lvl = 8'hFF;
    latch_m = 8'hFF;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 pd_en", pd_en, 8'h00);
    chk("R1 pu_en", pu_en, 8'hFF);
    chk("R1 od pu_en", pu_en_od, 8'h00);
    chk("R1 rd idle", rd_data, 8'h00);
    rd_latch_en = 1'b1; #1;
    chk("R1 latch all ones", rd_data, 8'hFF);
    rd_latch_en = 1'b0;

    // R2 R3 R4 directed write, bit order LSB
    do_write(8'h01);
    chk("R3 pd_en after 01", pd_en, 8'hFE);
    chk("R4 pu_en after 01", pu_en, 8'h01);
    chk("R4 od pu_en zero", pu_en_od, 8'h00);
    chk("R3 od pd_en", pd_en_od, 8'hFE);
    // R2 hold with wr_en low and changing wr_data
    repeat (3) @(negedge clk);
    chk("R2 hold", pd_en, 8'hFE);

    // R9 inputs: latch 1, outside level high then low
    do_write(8'hFF);
    set_ext_settle(8'hFF);
    rd_pin_en = 1'b1; #1; chk("R9 input high", rd_data, 8'hFF); rd_pin_en = 1'b0;
    set_ext_settle(8'h5A);
    rd_pin_en = 1'b1; #1; chk("R9 input mixed", rd_data, 8'h5A); rd_pin_en = 1'b0;
    // R9 latch-0 bits read back low
    do_write(8'h0F);
    set_ext_settle(8'hFF);
    rd_pin_en = 1'b1; #1; chk("R9 latch0 reads low", rd_data, 8'h0F); rd_pin_en = 1'b0;

    // R6 two-edge latency
    do_write(8'hFF);
    set_ext_settle(8'hC3);
    @(negedge clk); ext_lvl = 8'h3C;
    @(negedge clk); rd_pin_en = 1'b1; #1;
    chk("R6 one edge old value", rd_data, 8'hC3);
    @(negedge clk); #1;
    chk("R6 two edges new value", rd_data, 8'h3C);
    rd_pin_en = 1'b0;

    // random mix
    for (int k = 0; k < 60; k++) begin
      logic [7:0] v;
      v = $urandom();
      if ($urandom_range(0, 3) != 0) do_write(v);
      else begin
        @(negedge clk); wr_data = v;
        @(negedge clk);
        chk("R2 no write keeps latch", pd_en, ~latch_m);
      end
      set_ext_settle($urandom());
      chk("R3 rand pd_en", pd_en, ~latch_m);
      chk("R4 rand pu_en", pu_en, latch_m);
      chk("R4 rand od pu_en", pu_en_od, 8'h00);
      read_both_paths("rand");
    end

    summary();
  end
endmodule